// File: doc/BRIEF.md
# Double-Buffered Sliced Frame Buffer

This block stores two complete pages of a 256 x 192 frame buffer with one byte per pixel. Each pixel byte holds a packed color: red in bits [7:5], green in bits [4:2] and blue in bits [1:0]. The block treats that byte as opaque data. One page takes writes from a drawing engine. The other page is read, one byte at a time, by a video scan-out engine. A single page-select input decides which page plays which role. Flipping it at the end of a frame gives tear-free double buffering.

Each page is divided into twelve slices of 4096 bytes, and each slice holds 16 screen rows. A write is normally steered to one slice by the upper address bits. When the lane mask is non-zero, the same word is instead written into every selected slice at the same in-slice offset. With all twelve lanes on, a whole page can be filled with one color in 1024 word writes.

A pixel at column x and row y sits at byte address {y, x}. Each row therefore takes 256 consecutive bytes.

Top module: `fb_dbuf`

## Requirements
- R1: A byte address is {row[7:0], col[7:0]}. Valid addresses are 0 to 49151. Bits [15:12] select the slice (0 to 11), and bits [11:0] are the offset inside that slice.
- R2: A write stores 32 bits at the word that holds wr_addr, and wr_addr[1:0] is ignored. Byte-enable bit i writes wr_data[8i+7:8i] to byte address {wr_addr[15:2], i}, and bytes whose enable is clear keep their old value.
- R3: When lane_mask is zero, only the slice wr_addr[15:12] is written. A write whose byte address is 49152 or above changes nothing in either page.
- R4: When lane_mask is non-zero, every slice s whose bit lane_mask[s] is 1 is written at offset wr_addr[11:0]. The slice bits of wr_addr are then ignored, so twelve lanes clear a whole page in 1024 writes.
- R5: Writes go only to the page equal to the page_sel value sampled at the previous clock edge. The other page is the displayed page, and it is never written.
- R6: rd_data shows the displayed-page byte at the rd_addr sampled at a clock edge. It is valid from that edge until the next one, which is a latency of one clock.
- R7: When the sampled rd_addr is 49152 or above, rd_data is 0.
- R8: A change of page_sel affects both ports at the following edge. A write and a read issued in the same cycle as the change still use the old roles.
- R9: After reset, rd_data is 0 and page 0 is the page that receives writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_sel | input | 1 | Page that receives writes from the next edge on; the other page is displayed |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write byte address {row, col} |
| wr_data | input | 32 | Four pixel bytes; byte i goes to address base + i |
| wr_be | input | 4 | Byte enables |
| lane_mask | input | 12 | Forces the write into every selected slice |
| rd_addr | input | 16 | Scan-out byte address {row, col} |
| rd_data | output | 8 | Displayed pixel byte, one clock after rd_addr |

## Verification
A write takes effect at the edge where wr_en is sampled. Its data can only be seen after a page flip, so the bench updates its byte model at that edge and reads the bytes back once the page has become the displayed one. A read result is registered at the edge that samples rd_addr. The bench therefore compares rd_data one nanosecond after that edge, and in one directed case also just before the edge, where the previous byte must still be present. The page-flip check drives page_sel, a write and a read in the same cycle. It expects the old roles in that cycle and the new roles one cycle later.

// File: rtl/fb_pkg.sv
// Shared constants for the double-buffered frame buffer.
// Assumes byte-sized pixels and exactly two pages.
package fb_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned NUM_PAGES = 2;
endpackage

// File: rtl/fb_slice_ram.sv
// One slice of a page: a word-wide RAM with per-byte write enables and a
// registered read port.
// Assumes one write port and one read port, with no read-during-write
// ordering required (reads and writes target different pages).
module fb_slice_ram #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 1024,
    localparam int unsigned LANES = DATA_W / fb_pkg::BYTE_W,
    localparam int unsigned AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wbe,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rword
);
    logic [DATA_W-1:0] mem [WORDS];

    // Store the enabled byte lanes of the incoming word.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < LANES; b++) begin
                if (wbe[b]) begin
                    mem[waddr][b*fb_pkg::BYTE_W +: fb_pkg::BYTE_W] <= wdata[b*fb_pkg::BYTE_W +: fb_pkg::BYTE_W];
                end
            end
        end
    end

    // Register the addressed word for the scan-out side.
    always_ff @(posedge clk) begin
        rword <= mem[raddr];
    end
endmodule

// File: rtl/fb_lane_decode.sv
// Turns a write request into per-slice write enables.
// With a zero lane mask, the slice index picks at most one slice, and an
// index beyond the last slice picks none. With a non-zero mask, the mask
// itself selects the slices and the index is ignored.
module fb_lane_decode #(
    parameter int unsigned SLICES = 12,
    parameter int unsigned SIDX_W = 4
) (
    input  logic              wr_en,
    input  logic [SIDX_W-1:0] wr_sidx,
    input  logic [SLICES-1:0] lane_mask,
    output logic [SLICES-1:0] slice_we
);
    // Pick the target slices for the current write.
    always_comb begin
        slice_we = '0;
        if (wr_en) begin
            if (lane_mask != '0) begin
                slice_we = lane_mask;
            end else begin
                for (int s = 0; s < SLICES; s++) begin
                    if (wr_sidx == SIDX_W'(s)) slice_we[s] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fb_page.sv
// One page of the frame buffer: SLICES slice RAMs, the write decoder and
// the read-word multiplexer.
// Assumes the caller gates wr_en with the page's write role. The read word
// appears one clock after rd_sidx/rd_word are presented, and it is zero when
// the slice index is out of range.
module fb_page #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SLICES = 12,
    parameter int unsigned WORDS  = 1024,
    parameter int unsigned SIDX_W = 4,
    localparam int unsigned LANES = DATA_W / fb_pkg::BYTE_W,
    localparam int unsigned WAW   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SIDX_W-1:0] wr_sidx,
    input  logic [WAW-1:0]    wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic [SLICES-1:0] lane_mask,
    input  logic [SIDX_W-1:0] rd_sidx,
    input  logic [WAW-1:0]    rd_word,
    output logic [DATA_W-1:0] rd_wdata
);
    logic [SLICES-1:0] slice_we;
    logic [DATA_W-1:0] slice_rd [SLICES];
    logic [SIDX_W-1:0] rd_sidx_q;

    fb_lane_decode #(
        .SLICES (SLICES),
        .SIDX_W (SIDX_W)
    ) u_dec (
        .wr_en     (wr_en),
        .wr_sidx   (wr_sidx),
        .lane_mask (lane_mask),
        .slice_we  (slice_we)
    );

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        fb_slice_ram #(
            .DATA_W (DATA_W),
            .WORDS  (WORDS)
        ) u_ram (
            .clk   (clk),
            .we    (slice_we[s]),
            .waddr (wr_word),
            .wdata (wr_data),
            .wbe   (wr_be),
            .raddr (rd_word),
            .rword (slice_rd[s])
        );
    end

    // Remember which slice the pending read word comes from.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_sidx_q <= '0;
        else        rd_sidx_q <= rd_sidx;
    end

    // Select the word of the slice that was addressed.
    always_comb begin
        rd_wdata = '0;
        for (int s = 0; s < SLICES; s++) begin
            if (rd_sidx_q == SIDX_W'(s)) rd_wdata = slice_rd[s];
        end
    end

    AST_SINGLE_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mask == '0) |-> $onehot0(slice_we)); // R3
    AST_OOR_SLICE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lane_mask == '0 && wr_sidx >= SIDX_W'(SLICES)) |-> (slice_we == '0)); // R3
    AST_LANES_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lane_mask != '0) |-> (slice_we == lane_mask)); // R4
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (slice_we == '0)); // R5
endmodule

// File: rtl/fb_dbuf.sv
// Two-page frame buffer with a sliced write path and a byte read path.
// The registered page select gives the writable page; the other page is
// scanned out. The read byte is registered together with its page, byte
// lane and range flag, so rd_data follows rd_addr by one clock.
// Assumes ROWS is a multiple of ROWS_PER_SLICE and COLS and ROWS are powers
// of two or fit the {row, col} address form.
module fb_dbuf #(
    parameter int unsigned COLS           = 256,
    parameter int unsigned ROWS           = 192,
    parameter int unsigned ROWS_PER_SLICE = 16,
    parameter int unsigned DATA_W         = 32,
    localparam int unsigned LANES       = DATA_W / fb_pkg::BYTE_W,
    localparam int unsigned BOFS_W      = $clog2(LANES),
    localparam int unsigned SLICES      = ROWS / ROWS_PER_SLICE,
    localparam int unsigned SLICE_BYTES = COLS * ROWS_PER_SLICE,
    localparam int unsigned SOFS_W      = $clog2(SLICE_BYTES),
    localparam int unsigned WORDS       = SLICE_BYTES / LANES,
    localparam int unsigned WAW         = SOFS_W - BOFS_W,
    localparam int unsigned ADDR_W      = $clog2(COLS) + $clog2(ROWS),
    localparam int unsigned SIDX_W      = ADDR_W - SOFS_W,
    localparam int unsigned PIX_LIMIT   = COLS * ROWS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      page_sel,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [LANES-1:0]          wr_be,
    input  logic [SLICES-1:0]         lane_mask,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [fb_pkg::BYTE_W-1:0] rd_data
);
    logic                        page_q;
    logic                        rd_pg_q;
    logic [BOFS_W-1:0]           rd_byte_q;
    logic                        rd_ok_q;
    logic [fb_pkg::NUM_PAGES-1:0] pg_we;
    logic [DATA_W-1:0]           pg_rd [fb_pkg::NUM_PAGES];

    // Latch the page roles; the new roles apply from the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) page_q <= 1'b0;
        else        page_q <= page_sel;
    end

    // Remember the page, byte lane and range of the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pg_q   <= 1'b0;
            rd_byte_q <= '0;
            rd_ok_q   <= 1'b0;
        end else begin
            rd_pg_q   <= ~page_q;
            rd_byte_q <= rd_addr[BOFS_W-1:0];
            rd_ok_q   <= (rd_addr < ADDR_W'(PIX_LIMIT));
        end
    end

    for (genvar p = 0; p < fb_pkg::NUM_PAGES; p++) begin : g_page
        assign pg_we[p] = wr_en && (page_q == 1'(p));

        fb_page #(
            .DATA_W (DATA_W),
            .SLICES (SLICES),
            .WORDS  (WORDS),
            .SIDX_W (SIDX_W)
        ) u_page (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (pg_we[p]),
            .wr_sidx   (wr_addr[ADDR_W-1:SOFS_W]),
            .wr_word   (wr_addr[SOFS_W-1:BOFS_W]),
            .wr_data   (wr_data),
            .wr_be     (wr_be),
            .lane_mask (lane_mask),
            .rd_sidx   (rd_addr[ADDR_W-1:SOFS_W]),
            .rd_word   (rd_addr[SOFS_W-1:BOFS_W]),
            .rd_wdata  (pg_rd[p])
        );
    end

    // Pick the addressed byte from the displayed page's word.
    always_comb begin
        rd_data = '0;
        if (rd_ok_q) rd_data = pg_rd[rd_pg_q][rd_byte_q*fb_pkg::BYTE_W +: fb_pkg::BYTE_W];
    end

    AST_ONE_PAGE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pg_we)); // R5
    AST_NO_DISP_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_we != '0) |-> (pg_we[page_q] && !pg_we[~page_q])); // R5
    AST_SEL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (page_sel != page_q) |=> (page_q != $past(page_q))); // R8
    AST_RD_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= ADDR_W'(PIX_LIMIT)) |=> (rd_data == '0)); // R7
endmodule

// File: tb/fb_dbuf_bench.sv
module fb_dbuf_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [11:0] lane_mask = '0;
    logic [15:0] rd_addr = '0;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic wp = 1'b0;                 // page that receives writes (bench view)
    logic [7:0] mdl [2][49152];
    logic [15:0] rec [300];

    always #2 clk = ~clk;

    fb_dbuf u_fb_dbuf (
        .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .lane_mask(lane_mask), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic p, input logic [15:0] a);
        if (a < 16'd49152) return mdl[p][a];
        return 8'h00;
    endfunction

    task automatic model_wr(input logic p, input logic [15:0] a, input logic [31:0] d,
                            input logic [3:0] be, input logic [11:0] m);
        for (int i = 0; i < 4; i++) begin
            if (be[i]) begin
                logic [15:0] ba;
                ba = {a[15:2], 2'(i)};
                if (m != 0) begin
                    for (int s = 0; s < 12; s++)
                        if (m[s]) mdl[p][s*4096 + int'(ba[11:0])] = d[8*i +: 8];
                end else if (ba < 16'd49152) begin
                    mdl[p][ba] = d[8*i +: 8];
                end
            end
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be, input logic [11:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be; lane_mask = m;
        model_wr(wp, a, d, be, m);
        @(posedge clk);
    endtask

    task automatic rchk(input string tag, input logic [15:0] a);
        logic [7:0] e;
        @(negedge clk);
        wr_en = 1'b0; rd_addr = a;
        e = exp_rd(~wp, a);
        @(posedge clk);
        #1;
        chk(tag, {24'd0, rd_data}, {24'd0, e});
    endtask

    task automatic set_page(input logic s);
        @(negedge clk);
        wr_en = 1'b0; page_sel = s;
        @(posedge clk);
        wp = s;
    endtask

    task automatic clear_page(input logic [31:0] d);
        for (int w = 0; w < 1024; w++)
            wr({4'($urandom % 16), 10'(w), 2'($urandom % 4)}, d, 4'hF, 12'hFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R9 reset rd_data", {24'd0, rd_data}, 32'd0);

        // R9: page 0 is writable after reset; R4: fast clear
        clear_page(32'h1CE349B6);
        set_page(1'b1);
        for (int k = 0; k < 100; k++) rchk("R4 clear page0", 16'($urandom % 49152));
        for (int k = 0; k < 8; k++) rchk("R7 oor read", 16'(49152 + ($urandom % 16384)));
        rchk("R1 last pixel", 16'd49151);

        clear_page(32'h00FF7E81);
        for (int k = 0; k < 50; k++) rchk("R5 disp page kept", 16'($urandom % 49152));

        // random writes into page 1 while page 0 is displayed
        for (int k = 0; k < 300; k++) begin
            logic [15:0] a;
            logic [11:0] m;
            a = 16'($urandom);
            m = (($urandom % 8) == 0) ? 12'($urandom) : 12'h000;
            rec[k] = a;
            wr(a, $urandom, 4'($urandom), m);
            if ((k % 10) == 0) rchk("R5 disp during writes", 16'($urandom % 49152));
        end
        // R3: out-of-range write must not alias into any slice
        wr(16'hC010, 32'hDEADBEEF, 4'hF, 12'h000);
        wr(16'hF7F4, 32'h12345678, 4'hF, 12'h000);
        // R4: partial mask, slice bits ignored
        wr(16'hF124, 32'hA1B2C3D4, 4'b1011, 12'b1010_0000_0101);

        // R8: flip in the same cycle as a write and a read
        @(negedge clk);
        page_sel = ~wp; wr_en = 1'b1; wr_addr = 16'h5A40; wr_data = 32'h0BADF00D;
        wr_be = 4'hF; lane_mask = 12'h000; rd_addr = 16'h5A41;
        model_wr(wp, 16'h5A40, 32'h0BADF00D, 4'hF, 12'h000);
        @(posedge clk); #1;
        chk("R8 old roles", {24'd0, rd_data}, {24'd0, exp_rd(~wp, 16'h5A41)});
        wp = ~wp;
        rchk("R8 new roles", 16'h5A41);

        // page 1 now displayed: read back every recorded write
        for (int k = 0; k < 300; k++) begin
            for (int i = 0; i < 4; i++) rchk("R2 byte lanes", {rec[k][15:2], 2'(i)});
            rchk("R3 alias", {4'h0, rec[k][11:0]});
        end
        rchk("R3 oor alias0", 16'h0010);
        rchk("R3 oor alias2", 16'h2010);
        rchk("R3 oor alias11", 16'hB7F4);
        for (int s = 0; s < 12; s++)
            for (int i = 0; i < 4; i++) rchk("R4 partial mask", 16'(s*4096 + 16'h124 + i));

        // R6: one-clock latency, previous byte held until the edge
        rchk("R6 first", 16'h0124);
        @(negedge clk);
        rd_addr = 16'h2125;
        #1;
        chk("R6 held before edge", {24'd0, rd_data}, {24'd0, exp_rd(~wp, 16'h0124)});
        @(posedge clk); #1;
        chk("R6 new after edge", {24'd0, rd_data}, {24'd0, exp_rd(~wp, 16'h2125)});

        set_page(1'b1);
        for (int k = 0; k < 50; k++) rchk("R5 page0 untouched", 16'($urandom % 49152));

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule